// File: doc/BRIEF.md
# Interrupt Source Controller with Reject and Resend

This block is the source side of a two-level interrupt fabric. It owns a small set of message-style interrupt sources. Each source holds a target server index and an 8-bit priority. A priority of 0xFF means masked. A one-cycle event pulse on an unmasked source becomes a request toward the presentation layer. The request carries the server, the global source number and the priority, and it uses a valid/ready handshake. An event on a masked source is only remembered as masked-pending. A later configuration write that unmasks the source replays it.

The presentation layer may refuse a request it cannot take. It does this with a reject pulse that names the global source number, and the source is then flagged as rejected. A resend command starts a sequential scan over all sources in ascending index order. The scan clears each rejected flag and re-issues the request if the source is not masked. The scan issues at most one request per cycle and waits while ready is low. Global numbers are the local index plus a fixed offset of 16. Configuration reads and writes check their arguments and return a status one cycle later: 0x00 for success and 0xFD (−3 as a signed byte) for refusal.

The control is a two-state machine:
- **IDLE**: events and unmask replays may issue directly.
- **SCAN**: the scan owns the request output.

The transitions are:
- **START_SCAN**: IDLE to SCAN on a resend command.
- **STEP**: SCAN to SCAN, advancing one index.
- **STALL**: SCAN holds its index on a rejected, unmasked source while the output is occupied.
- **FINISH_SCAN**: SCAN to IDLE after the last index is passed.

A resend command that arrives while the machine is in SCAN is ignored.

Top module: `isc_source_ctrl`

## Requirements
- R1: After reset every source reads back server 0 and priority 0xFF, no request is valid, and no event produces a request until a source is unmasked.
- R2: Global source number = local index + 16. Only numbers 16..23 (default 8 sources) are accepted, and every request carries a number in that range.
- R3: An event on a source whose priority is 0xFF sets its masked-pending flag and issues no request. A request never carries priority 0xFF.
- R4: In IDLE with the output free, an unmasked event issues a request in the cycle after the pulse, carrying the source's configured server and priority.
- R5: A configuration write is refused with status 0xFD and leaves the source unchanged when any of these holds: the number is outside the valid range, the server index is 4 or more (default 4 servers), or the 9-bit priority exceeds 255. Otherwise the write stores the values and returns 0x00. The status and a done pulse appear one cycle after the command.
- R6: A configuration read returns status 0x00 with the stored server and priority. For an invalid number it returns 0xFD, with server and priority both zero.
- R7: A write with priority other than 0xFF to a masked-pending source clears the flag and issues one request with the new server and priority. A repeated write issues nothing.
- R8: A reject pulse with a valid number sets that source's rejected flag. A resend scan re-issues the rejected, unmasked sources in ascending index order and clears their flags. A reject pulse with an invalid number is ignored.
- R9: The scan clears the rejected flag of a masked source without issuing a request. A second resend with no new rejects issues nothing.
- R10: While a request is valid and ready is low, the request stays valid with a stable payload, and the scan does not move past a source it must issue.
- R11: When several unmasked events coincide in IDLE, only the lowest index issues, and the others are flagged rejected. Any unmasked event during SCAN is also flagged rejected, and both kinds are re-issued by a later resend.
- R12: When an unmask replay falls in the same cycle as an issuing event, the event wins and the replayed source is flagged rejected instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt_i | input | NSRC | One-cycle event pulse per source |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Presentation layer accepts request |
| req_server_o | output | SRV_W | Target server of the request |
| req_num_o | output | NUM_W | Global source number of the request |
| req_prio_o | output | 8 | Priority of the request |
| rej_valid_i | input | 1 | Reject pulse |
| rej_num_i | input | NUM_W | Global number being rejected |
| resend_i | input | 1 | Start a resend scan |
| cfg_wr_i | input | 1 | Configuration write command |
| cfg_rd_i | input | 1 | Configuration read command (a write in the same cycle wins) |
| cfg_num_i | input | NUM_W | Global source number for the command |
| cfg_server_i | input | SRV_IN_W | Server index to write |
| cfg_prio_i | input | 9 | Priority to write (values above 255 are refused) |
| cfg_done_o | output | 1 | Command response valid |
| cfg_status_o | output | 8 | 0x00 success, 0xFD refused |
| cfg_rd_server_o | output | SRV_W | Read-back server |
| cfg_rd_prio_o | output | 8 | Read-back priority |

## Verification
Two pairs of functions can land in the same cycle:
- **Event issue and unmask replay.** Both compete for the single output slot. The bench raises an event on an unmasked source in the very cycle a write unmasks a masked-pending one. It judges the result by the request seen next, and by the replayed source appearing only after a resend.
- **Event and scan.** An event can also collide with a running scan. The bench stalls the scan with ready low, injects an event on an index already passed, and expects that source only from the following resend.

Sweeps over all source numbers, valid and invalid, compute each expected status, number and priority arithmetically from the index.

// File: rtl/isc_pkg.sv
package isc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    localparam logic [7:0] STAT_OK     = 8'h00;
    localparam logic [7:0] STAT_BADARG = 8'hFD;
    localparam logic [7:0] PRIO_MASKED = 8'hFF;
endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot #(
    parameter int SRV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [SRV_W-1:0] wr_srv_i,
    input  logic [7:0]       wr_prio_i,
    input  logic             set_mp_i,
    input  logic             clr_mp_i,
    input  logic             set_rj_i,
    input  logic             clr_rj_i,
    output logic [SRV_W-1:0] srv_o,
    output logic [7:0]       prio_o,
    output logic             mp_o,
    output logic             rj_o
);
    import isc_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srv_o  <= '0;
            prio_o <= PRIO_MASKED;
            mp_o   <= 1'b0;
            rj_o   <= 1'b0;
        end else begin
            if (wr_en_i) begin
                srv_o  <= wr_srv_i;
                prio_o <= wr_prio_i;
            end
            // a set in the same cycle as a clear wins
            if (set_mp_i)      mp_o <= 1'b1;
            else if (clr_mp_i) mp_o <= 1'b0;
            if (set_rj_i)      rj_o <= 1'b1;
            else if (clr_rj_i) rj_o <= 1'b0;
        end
    end
endmodule

// File: rtl/isc_scan_ctrl.sv
module isc_scan_ctrl #(
    parameter int NSRC   = 8,
    parameter int SRV_W  = 2,
    parameter int NUM_W  = 8,
    parameter int OFFSET = 16,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC-1:0]            evt_i,
    input  logic [NSRC-1:0][7:0]       prio_i,
    input  logic [NSRC-1:0][SRV_W-1:0] srv_i,
    input  logic [NSRC-1:0]            mp_i,
    input  logic [NSRC-1:0]            rj_i,
    input  logic                       wr_ok_i,
    input  logic [IDX_W-1:0]           wr_idx_i,
    input  logic [SRV_W-1:0]           wr_srv_i,
    input  logic [7:0]                 wr_prio_i,
    input  logic                       resend_i,
    input  logic                       req_ready_i,
    output logic [NSRC-1:0]            set_mp_o,
    output logic [NSRC-1:0]            clr_mp_o,
    output logic [NSRC-1:0]            set_rj_o,
    output logic [NSRC-1:0]            clr_rj_o,
    output logic                       req_valid_o,
    output logic [SRV_W-1:0]           req_srv_o,
    output logic [NUM_W-1:0]           req_num_o,
    output logic [7:0]                 req_prio_o
);
    import isc_pkg::*;

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [NSRC-1:0]  masked, ev_unm, ev_first, wr_hot, scan_hot;
    logic [IDX_W-1:0] evt_idx;
    logic out_free, slot_free, issue_evt, wr_replay, wr_issue;
    logic scan_on, cur_rej, cur_mask, scan_issue, scan_adv, last_idx;

    always_comb begin
        evt_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            masked[i] = (prio_i[i] == PRIO_MASKED);
            if (ev_first[i]) evt_idx = IDX_W'(i);
        end
    end

    assign out_free  = !req_valid_o || req_ready_i;
    assign slot_free = (state_q == ST_IDLE) && out_free;
    assign ev_unm    = evt_i & ~masked;
    assign ev_first  = ev_unm & (~ev_unm + 1'b1);   // lowest set bit
    assign issue_evt = slot_free && (|ev_unm);
    assign wr_hot    = NSRC'(1) << wr_idx_i;
    assign wr_replay = wr_ok_i && mp_i[wr_idx_i] && (wr_prio_i != PRIO_MASKED);
    assign wr_issue  = wr_replay && slot_free && !issue_evt;

    assign scan_on    = (state_q == ST_SCAN);
    assign cur_rej    = rj_i[idx_q];
    assign cur_mask   = masked[idx_q];
    assign scan_issue = scan_on && cur_rej && !cur_mask && out_free;
    assign scan_adv   = scan_on && (!cur_rej || cur_mask || out_free);
    assign last_idx   = (idx_q == IDX_W'(NSRC - 1));
    assign scan_hot   = NSRC'(1) << idx_q;

    assign set_mp_o = evt_i & masked;
    assign clr_mp_o = wr_replay ? wr_hot : '0;
    assign set_rj_o = (ev_unm & ~(issue_evt ? ev_first : '0))
                    | ((wr_replay && !wr_issue) ? wr_hot : '0);
    assign clr_rj_o = (scan_on && cur_rej && scan_adv) ? scan_hot : '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START_SCAN, STEP, STALL, FINISH_SCAN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (resend_i) state_d = ST_SCAN;
            ST_SCAN: if (scan_adv && last_idx) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs: scan index and request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            req_valid_o <= 1'b0;
            req_srv_o   <= '0;
            req_num_o   <= '0;
            req_prio_o  <= '0;
        end else begin
            if (state_q == ST_IDLE)
                idx_q <= '0;
            else if (scan_adv)
                idx_q <= last_idx ? '0 : idx_q + 1'b1;

            if (issue_evt) begin
                req_valid_o <= 1'b1;
                req_srv_o   <= srv_i[evt_idx];
                req_num_o   <= NUM_W'(OFFSET) + NUM_W'(evt_idx);
                req_prio_o  <= prio_i[evt_idx];
            end else if (wr_issue) begin
                req_valid_o <= 1'b1;
                req_srv_o   <= wr_srv_i;
                req_num_o   <= NUM_W'(OFFSET) + NUM_W'(wr_idx_i);
                req_prio_o  <= wr_prio_i;
            end else if (scan_issue) begin
                req_valid_o <= 1'b1;
                req_srv_o   <= srv_i[idx_q];
                req_num_o   <= NUM_W'(OFFSET) + NUM_W'(idx_q);
                req_prio_o  <= prio_i[idx_q];
            end else if (req_ready_i) begin
                req_valid_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/isc_source_ctrl.sv
module isc_source_ctrl #(
    parameter int NSRC     = 8,
    parameter int NSERVERS = 4,
    parameter int NUM_W    = 8,
    parameter int SRV_IN_W = 8,
    parameter int OFFSET   = 16,
    localparam int SRV_W   = (NSERVERS > 1) ? $clog2(NSERVERS) : 1,
    localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_evt_i,
    output logic                req_valid_o,
    input  logic                req_ready_i,
    output logic [SRV_W-1:0]    req_server_o,
    output logic [NUM_W-1:0]    req_num_o,
    output logic [7:0]          req_prio_o,
    input  logic                rej_valid_i,
    input  logic [NUM_W-1:0]    rej_num_i,
    input  logic                resend_i,
    input  logic                cfg_wr_i,
    input  logic                cfg_rd_i,
    input  logic [NUM_W-1:0]    cfg_num_i,
    input  logic [SRV_IN_W-1:0] cfg_server_i,
    input  logic [8:0]          cfg_prio_i,
    output logic                cfg_done_o,
    output logic [7:0]          cfg_status_o,
    output logic [SRV_W-1:0]    cfg_rd_server_o,
    output logic [7:0]          cfg_rd_prio_o
);
    import isc_pkg::*;

    logic [NSRC-1:0][7:0]       prio_all;
    logic [NSRC-1:0][SRV_W-1:0] srv_all;
    logic [NSRC-1:0]            mp_all, rj_all;
    logic [NSRC-1:0]            set_mp, clr_mp, set_rj, clr_rj;
    logic cfg_num_ok, srv_ok, prio_ok, wr_ok, rej_ok;
    logic [IDX_W-1:0] cfg_idx, rej_idx;

    assign cfg_num_ok = (int'(cfg_num_i) >= OFFSET) && (int'(cfg_num_i) < OFFSET + NSRC);
    assign rej_ok     = rej_valid_i && (int'(rej_num_i) >= OFFSET)
                                    && (int'(rej_num_i) < OFFSET + NSRC);
    assign srv_ok     = int'(cfg_server_i) < NSERVERS;
    assign prio_ok    = (cfg_prio_i <= 9'd255);
    assign wr_ok      = cfg_wr_i && cfg_num_ok && srv_ok && prio_ok;
    assign cfg_idx    = IDX_W'(cfg_num_i - NUM_W'(OFFSET));
    assign rej_idx    = IDX_W'(rej_num_i - NUM_W'(OFFSET));

    for (genvar g = 0; g < NSRC; g++) begin : g_slot
        isc_src_slot #(.SRV_W(SRV_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_ok && (cfg_idx == IDX_W'(g))),
            .wr_srv_i  (SRV_W'(cfg_server_i)),
            .wr_prio_i (cfg_prio_i[7:0]),
            .set_mp_i  (set_mp[g]),
            .clr_mp_i  (clr_mp[g]),
            .set_rj_i  (set_rj[g] | (rej_ok && (rej_idx == IDX_W'(g)))),
            .clr_rj_i  (clr_rj[g]),
            .srv_o     (srv_all[g]),
            .prio_o    (prio_all[g]),
            .mp_o      (mp_all[g]),
            .rj_o      (rj_all[g])
        );
    end

    isc_scan_ctrl #(
        .NSRC(NSRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .OFFSET(OFFSET)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (src_evt_i),
        .prio_i      (prio_all),
        .srv_i       (srv_all),
        .mp_i        (mp_all),
        .rj_i        (rj_all),
        .wr_ok_i     (wr_ok),
        .wr_idx_i    (cfg_idx),
        .wr_srv_i    (SRV_W'(cfg_server_i)),
        .wr_prio_i   (cfg_prio_i[7:0]),
        .resend_i    (resend_i),
        .req_ready_i (req_ready_i),
        .set_mp_o    (set_mp),
        .clr_mp_o    (clr_mp),
        .set_rj_o    (set_rj),
        .clr_rj_o    (clr_rj),
        .req_valid_o (req_valid_o),
        .req_srv_o   (req_server_o),
        .req_num_o   (req_num_o),
        .req_prio_o  (req_prio_o)
    );

    // configuration response, one cycle after the command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_done_o      <= 1'b0;
            cfg_status_o    <= STAT_OK;
            cfg_rd_server_o <= '0;
            cfg_rd_prio_o   <= '0;
        end else begin
            cfg_done_o      <= cfg_wr_i || cfg_rd_i;
            cfg_rd_server_o <= '0;
            cfg_rd_prio_o   <= '0;
            if (cfg_wr_i) begin
                cfg_status_o <= wr_ok ? STAT_OK : STAT_BADARG;
            end else if (cfg_rd_i) begin
                cfg_status_o <= cfg_num_ok ? STAT_OK : STAT_BADARG;
                if (cfg_num_ok) begin
                    cfg_rd_server_o <= srv_all[cfg_idx];
                    cfg_rd_prio_o   <= prio_all[cfg_idx];
                end
            end
        end
    end
endmodule

// File: rtl/isc_source_ctrl_chk.sv
module isc_source_ctrl_chk #(
    parameter int NUM_W  = 8,
    parameter int SRV_W  = 2,
    parameter int NSRC   = 8,
    parameter int OFFSET = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SRV_W-1:0] req_server,
    input logic [NUM_W-1:0] req_num,
    input logic [7:0]       req_prio,
    input logic             cfg_wr,
    input logic             cfg_rd,
    input logic             cfg_done,
    input logic [7:0]       cfg_status
);
    p_stable_payload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable({req_server, req_num, req_prio})));

    p_num_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((int'(req_num) >= OFFSET) && (int'(req_num) < OFFSET + NSRC)));

    p_never_masked_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_prio != 8'hFF));

    p_done_follows_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> $past(cfg_wr || cfg_rd));

    p_status_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> ((cfg_status == 8'h00) || (cfg_status == 8'hFD)));
endmodule

bind isc_source_ctrl isc_source_ctrl_chk #(
    .NUM_W(NUM_W), .SRV_W(SRV_W), .NSRC(NSRC), .OFFSET(OFFSET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid_o),
    .req_ready  (req_ready_i),
    .req_server (req_server_o),
    .req_num    (req_num_o),
    .req_prio   (req_prio_o),
    .cfg_wr     (cfg_wr_i),
    .cfg_rd     (cfg_rd_i),
    .cfg_done   (cfg_done_o),
    .cfg_status (cfg_status_o)
);

// File: tb/isc_source_ctrl_bench.sv
`timescale 1ns/1ps
module isc_source_ctrl_bench;
    localparam int NSRC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] src_evt_i = '0;
    logic req_valid_o, req_ready_i = 1'b1;
    logic [1:0] req_server_o;
    logic [7:0] req_num_o, req_prio_o;
    logic rej_valid_i = 1'b0;
    logic [7:0] rej_num_i = '0;
    logic resend_i = 1'b0, cfg_wr_i = 1'b0, cfg_rd_i = 1'b0;
    logic [7:0] cfg_num_i = '0, cfg_server_i = '0;
    logic [8:0] cfg_prio_i = '0;
    logic cfg_done_o;
    logic [7:0] cfg_status_o;
    logic [1:0] cfg_rd_server_o;
    logic [7:0] cfg_rd_prio_o;

    isc_source_ctrl u_isc_source_ctrl (.*);

    always #4 clk = ~clk;

    int nchk = 0, nfail = 0, lg_n = 0, l0;
    int lg_num [0:255];
    int lg_prio[0:255];
    int e_srv [NSRC];
    int e_prio[NSRC];
    bit finished = 1'b0;

    task automatic check(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cyc();
        if (req_valid_o && req_ready_i) begin
            lg_num[lg_n]  = int'(req_num_o);
            lg_prio[lg_n] = int'(req_prio_o);
            lg_n++;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic cfg_write(input int num, input int srv, input int prio);
        cfg_wr_i = 1'b1; cfg_num_i = 8'(num); cfg_server_i = 8'(srv); cfg_prio_i = 9'(prio);
        cyc();
        cfg_wr_i = 1'b0;
    endtask

    task automatic cfg_read(input int num);
        cfg_rd_i = 1'b1; cfg_num_i = 8'(num);
        cyc();
        cfg_rd_i = 1'b0;
    endtask

    task automatic reject(input int num);
        rej_valid_i = 1'b1; rej_num_i = 8'(num);
        cyc();
        rej_valid_i = 1'b0;
    endtask

    task automatic resend();
        resend_i = 1'b1;
        cyc();
        resend_i = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        check("R1 req_valid after reset", int'(req_valid_o), 0);
        for (int i = 0; i < NSRC; i++) begin
            cfg_read(16 + i);
            check("R1 reset read status", int'(cfg_status_o), 0);
            check("R1 reset server", int'(cfg_rd_server_o), 0);
            check("R1 reset prio", int'(cfg_rd_prio_o), 255);
            e_srv[i] = 0; e_prio[i] = 255;
        end

        // R2 R6: number validity sweep
        for (int n = 0; n < 32; n++) begin
            cfg_read(n);
            check("R6 read done", int'(cfg_done_o), 1);
            check("R2 R6 read status", int'(cfg_status_o),
                  (n >= 16 && n < 24) ? 0 : 253);
            if (!(n >= 16 && n < 24))
                check("R6 invalid read prio zero", int'(cfg_rd_prio_o), 0);
        end

        // R3: masked event on source 3
        src_evt_i = 8'h08; cyc(); src_evt_i = '0;
        run(2);
        check("R3 masked event gives no request", lg_n + int'(req_valid_o), 0);

        // configure all but source 3
        for (int i = 0; i < NSRC; i++) begin
            if (i != 3) begin
                cfg_write(16 + i, i % 4, 8 * i + 4);
                check("R5 valid write status", int'(cfg_status_o), 0);
                e_srv[i] = i % 4; e_prio[i] = 8 * i + 4;
            end
        end
        check("R7 plain writes issue nothing", lg_n + int'(req_valid_o), 0);

        // R7: unmask replay of source 3
        cfg_write(19, 3, 28); e_srv[3] = 3; e_prio[3] = 28;
        check("R7 replay valid", int'(req_valid_o), 1);
        check("R7 replay num", int'(req_num_o), 19);
        check("R7 replay prio", int'(req_prio_o), 28);
        check("R7 replay server", int'(req_server_o), 3);
        cyc();
        cfg_write(19, 3, 28);
        run(2);
        check("R7 repeated write issues once", lg_n, 1);

        // R5: refused writes
        cfg_write(15, 1, 9);   check("R5 low num refused", int'(cfg_status_o), 253);
        cfg_write(24, 1, 9);   check("R5 high num refused", int'(cfg_status_o), 253);
        cfg_write(18, 4, 9);   check("R5 server refused", int'(cfg_status_o), 253);
        cfg_write(18, 1, 256); check("R5 prio refused", int'(cfg_status_o), 253);
        cfg_read(18);
        check("R5 unchanged server", int'(cfg_rd_server_o), e_srv[2]);
        check("R5 unchanged prio", int'(cfg_rd_prio_o), e_prio[2]);
        for (int i = 0; i < NSRC; i++) begin
            cfg_read(16 + i);
            check("R6 read server", int'(cfg_rd_server_o), e_srv[i]);
            check("R6 read prio", int'(cfg_rd_prio_o), e_prio[i]);
        end

        // R4 R2: single events per source
        for (int i = 0; i < NSRC; i++) begin
            src_evt_i = NSRC'(1) << i; cyc(); src_evt_i = '0;
            check("R4 event valid", int'(req_valid_o), 1);
            check("R2 R4 event num", int'(req_num_o), 16 + i);
            check("R4 event prio", int'(req_prio_o), e_prio[i]);
            check("R4 event server", int'(req_server_o), e_srv[i]);
            cyc();
        end

        // R11: coinciding events, lowest wins, others resent in order
        src_evt_i = 8'b1010_0110; cyc(); src_evt_i = '0;
        check("R11 lowest index wins", int'(req_num_o), 17);
        l0 = lg_n;
        resend(); run(12);
        check("R11 resend count", lg_n - l0, 4);
        check("R11 order 0", lg_num[l0], 17);
        check("R11 order 1", lg_num[l0 + 1], 18);
        check("R11 order 2", lg_num[l0 + 2], 21);
        check("R11 order 3", lg_num[l0 + 3], 23);
        check("R8 resend prio", lg_prio[l0 + 3], e_prio[7]);

        // R8 R9: rejects, masked reject dropped, invalid reject ignored
        cfg_write(20, 0, 255); e_prio[4] = 255;
        reject(22); reject(17); reject(20); reject(30); reject(5);
        l0 = lg_n;
        resend(); run(12);
        check("R8 R9 resend count", lg_n - l0, 2);
        check("R8 first", lg_num[l0], 17);
        check("R8 second", lg_num[l0 + 1], 22);
        l0 = lg_n;
        resend(); run(12);
        check("R9 second resend empty", lg_n - l0, 0);
        cfg_write(20, 0, 36); e_prio[4] = 36;
        run(2);
        check("R9 masked source not replayed", lg_n - l0, 0);

        // R10: stall with ready low
        req_ready_i = 1'b0;
        reject(18); reject(20);
        resend(); run(3);
        for (int k = 0; k < 5; k++) begin
            check("R10 held valid", int'(req_valid_o), 1);
            check("R10 held num", int'(req_num_o), 18);
            cyc();
        end
        req_ready_i = 1'b1;
        l0 = lg_n;
        run(12);
        check("R10 drained count", lg_n - l0, 2);
        check("R10 drained first", lg_num[l0], 18);
        check("R10 drained second", lg_num[l0 + 1], 20);

        // R12: replay collides with an event
        cfg_write(22, 1, 255); e_prio[6] = 255;
        src_evt_i = 8'h40; cyc(); src_evt_i = '0;
        src_evt_i = 8'h01;
        cfg_write(22, 1, 10); e_prio[6] = 10;
        src_evt_i = '0;
        check("R12 event wins", int'(req_num_o), 16);
        l0 = lg_n;
        resend(); run(12);
        check("R12 count", lg_n - l0, 2);
        check("R12 event first", lg_num[l0], 16);
        check("R12 replay via resend", lg_num[l0 + 1], 22);
        check("R12 replay prio", lg_prio[l0 + 1], 10);

        // R11: event during a stalled scan
        req_ready_i = 1'b0;
        reject(20); reject(23);
        resend(); run(9);
        src_evt_i = 8'h01; cyc(); src_evt_i = '0;
        check("R11 event in scan not issued", int'(req_num_o), 20);
        req_ready_i = 1'b1;
        l0 = lg_n;
        run(6);
        check("R11 scan count", lg_n - l0, 2);
        check("R11 scan last", lg_num[l0 + 1], 23);
        l0 = lg_n;
        resend(); run(12);
        check("R11 queued event count", lg_n - l0, 1);
        check("R11 queued event num", lg_num[l0], 16);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule